// File: doc/BRIEF.md
# Transaction-Counting Phase Barrier

This block is one reusable synchronization object for a producer/consumer pipeline. It tracks two debts at once. The first is the number of participant arrivals still missing from the current round. The second is the number of asynchronous transaction units, such as bytes, still in flight. Producers issue commands on a command port: initialize, arrive, announce expected transactions, or arrive and announce in one operation. A data mover reports finished transactions on a separate completion port.

A round ends only when both debts are zero. When it ends, the phase bit toggles and the arrival debt is reloaded for the next round, all in one register update. A one-cycle pulse marks each completed round. A waiter keeps a single local parity bit. It asks the test port whether the phase with that parity has finished, and it flips its bit after each round it consumes.

Top module: `txn_phase_barrier`

## Requirements
- R1: After reset the phase bit, pending count, transaction count, error flag and done pulse are all 0. Until the first init, every command and every completion report has no effect.
- R2: Init (`cmd_op` = 3'd1) loads the pending count with `cmd_arg[ARRIVE_W-1:0]`. It also clears the transaction count, the phase bit and the error flag, and arms the barrier.
- R3: Arrive (`cmd_op` = 3'd2) lowers the pending count by one. The pending count never exceeds the count loaded by the last init.
- R4: Expect (`cmd_op` = 3'd3) adds `cmd_arg` to the transaction count without touching the pending count. Arrive-with-expect (`cmd_op` = 3'd4) adds `cmd_arg` and also counts one arrival. Any other op code has no effect.
- R5: A completion report (`done_valid`) subtracts `done_amount` from the transaction count. When it falls in the same cycle as a command, both updates apply before the completion check.
- R6: A round completes in a cycle that carries an accepted command or completion report, if both counts are zero after that cycle's updates. `done_o` is high for exactly the following cycle.
- R7: An arrival that brings the pending count to zero while transactions remain outstanding does not complete the round.
- R8: On completion the phase bit toggles, the pending count reloads from the init count, and the transaction count is 0.
- R9: `test_done_o` is high exactly when `test_parity` differs from the current phase bit, meaning the phase with that parity has completed.
- R10: Each of the following raises `err_o` and is a faulting cycle:
  - an arrival at a pending count of 0, which leaves the count at 0;
  - a subtraction below zero, which saturates the transaction count at 0;
  - an addition above the maximum, which saturates it at all ones.

  A faulting cycle never completes a round. With `ERR_STICKY`=1 the flag holds until the next init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 1 init, 2 arrive, 3 expect, 4 arrive-with-expect |
| cmd_arg | input | TX_W | Init count (low ARRIVE_W bits) or transaction units to add |
| done_valid | input | 1 | Completion report strobe |
| done_amount | input | TX_W | Transaction units finished |
| test_parity | input | 1 | Parity bit held by the waiter |
| test_done_o | output | 1 | Phase with that parity has completed |
| phase_o | output | 1 | Current phase parity |
| pending_o | output | ARRIVE_W | Arrivals still missing this round |
| tx_count_o | output | TX_W | Outstanding transaction units |
| done_o | output | 1 | One-cycle round-completion pulse |
| err_o | output | 1 | Misuse flag |

## Verification
The bench builds the barrier with ARRIVE_W=4 and TX_W=6. Every arrival count from 1 to 15 is therefore reachable, and so is the transaction ceiling of 63, using short stimulus. Each count is swept through three round shapes, and each shape runs two rounds per init, so the reload and the parity flip are exercised back to back. The round shapes are:
- arrivals only;
- a fused arrival that leaves transactions outstanding after the last arrive;
- the final arrive and the final completion report landing in the same cycle.

Saturation at both ends of the transaction count, arrival underrun and unused op codes are reached directly at this width.

// File: rtl/txb_pkg.sv
package txb_pkg;
   typedef enum logic [2:0] {
      TXB_NOP     = 3'd0,
      TXB_INIT    = 3'd1,
      TXB_ARRIVE  = 3'd2,
      TXB_EXPECT  = 3'd3,
      TXB_ARR_EXP = 3'd4
   } txb_op_e;
endpackage

// File: rtl/txb_arrival_ctr.sv
module txb_arrival_ctr #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] load_val_i,
   input  logic          dec_i,
   input  logic          reload_i,
   output logic [AW-1:0] pend_o,
   output logic [AW-1:0] exp_o,
   output logic [AW-1:0] pend_nxt_o,
   output logic          underrun_o
);
   logic [AW-1:0] pend_q, exp_q;
   logic          at_zero;

   assign at_zero    = (pend_q == '0);
   assign underrun_o = dec_i & at_zero;
   assign pend_nxt_o = (dec_i && !at_zero) ? pend_q - AW'(1) : pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         exp_q  <= '0;
      end else if (load_i) begin
         pend_q <= load_val_i;
         exp_q  <= load_val_i;
      end else if (reload_i) begin
         pend_q <= exp_q;
      end else begin
         pend_q <= pend_nxt_o;
      end
   end

   assign pend_o = pend_q;
   assign exp_o  = exp_q;
endmodule

// File: rtl/txb_tx_ctr.sv
module txb_tx_ctr #(
   parameter int TW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic [TW-1:0] add_val_i,
   input  logic [TW-1:0] sub_val_i,
   output logic [TW-1:0] cnt_o,
   output logic [TW-1:0] cnt_nxt_o,
   output logic          fault_o
);
   localparam logic [TW:0] CEIL = {1'b0, {TW{1'b1}}};

   logic [TW-1:0] cnt_q;
   logic [TW:0]   sum_w, sat_w, diff_w;
   logic          ovf_w, under_w;

   always_comb begin
      sum_w     = {1'b0, cnt_q} + {1'b0, add_val_i};
      ovf_w     = sum_w[TW];
      sat_w     = ovf_w ? CEIL : sum_w;
      under_w   = ({1'b0, sub_val_i} > sat_w);
      diff_w    = sat_w - {1'b0, sub_val_i};
      cnt_nxt_o = under_w ? '0 : diff_w[TW-1:0];
      fault_o   = ovf_w | under_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else              cnt_q <= cnt_nxt_o;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/txb_phase_ctl.sv
module txb_phase_ctl #(
   parameter bit ERR_STICKY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init_i,
   input  logic event_i,
   input  logic fault_i,
   input  logic arr_zero_i,
   input  logic tx_zero_i,
   output logic complete_o,
   output logic phase_o,
   output logic armed_o,
   output logic done_o,
   output logic err_o
);
   logic phase_q, armed_q, done_q, err_q;

   assign complete_o = armed_q & ~init_i & event_i & ~fault_i & arr_zero_i & tx_zero_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         armed_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= complete_o;
         if (init_i) begin
            phase_q <= 1'b0;
            armed_q <= 1'b1;
         end else if (complete_o) begin
            phase_q <= ~phase_q;
         end
      end
   end

   generate
      if (ERR_STICKY) begin : g_err_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         err_q <= 1'b0;
            else if (init_i)                    err_q <= 1'b0;
            else if (armed_q && fault_i)        err_q <= 1'b1;
         end
      end else begin : g_err_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= armed_q & ~init_i & fault_i;
         end
      end
   endgenerate

   assign phase_o = phase_q;
   assign armed_o = armed_q;
   assign done_o  = done_q;
   assign err_o   = err_q;
endmodule

// File: rtl/txn_phase_barrier.sv
module txn_phase_barrier
   import txb_pkg::*;
#(
   parameter int ARRIVE_W   = 16,
   parameter int TX_W       = 20,
   parameter bit ERR_STICKY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [2:0]          cmd_op,
   input  logic [TX_W-1:0]     cmd_arg,
   input  logic                done_valid,
   input  logic [TX_W-1:0]     done_amount,
   input  logic                test_parity,
   output logic                test_done_o,
   output logic                phase_o,
   output logic [ARRIVE_W-1:0] pending_o,
   output logic [TX_W-1:0]     tx_count_o,
   output logic                done_o,
   output logic                err_o
);
   generate
      if (ARRIVE_W < 1) begin : g_bad_aw
         $error("ARRIVE_W must be at least 1");
      end
      if (TX_W < ARRIVE_W) begin : g_bad_tw
         $error("TX_W must be at least ARRIVE_W so cmd_arg carries the init count");
      end
   endgenerate

   txb_op_e op_w;
   logic    is_init, is_arr, is_add, is_known, act;
   logic    dec_w, event_w, complete_w, armed_w, fault_w;
   logic    underrun_w, tx_fault_w;
   logic [ARRIVE_W-1:0] pend_w, exp_w, pend_nxt_w;
   logic [TX_W-1:0]     add_w, sub_w, tx_w, tx_nxt_w;

   assign op_w     = txb_op_e'(cmd_op);
   assign is_init  = cmd_valid && (op_w == TXB_INIT);
   assign is_arr   = cmd_valid && ((op_w == TXB_ARRIVE) || (op_w == TXB_ARR_EXP));
   assign is_add   = cmd_valid && ((op_w == TXB_EXPECT) || (op_w == TXB_ARR_EXP));
   assign is_known = is_arr | is_add;
   assign act      = armed_w & ~is_init;

   assign dec_w   = act & is_arr;
   assign add_w   = (act & is_add) ? cmd_arg : '0;
   assign sub_w   = (act & done_valid) ? done_amount : '0;
   assign event_w = act & (is_known | done_valid);
   assign fault_w = act & (underrun_w | tx_fault_w);

   txb_arrival_ctr #(.AW(ARRIVE_W)) u_arr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (is_init),
      .load_val_i (cmd_arg[ARRIVE_W-1:0]),
      .dec_i      (dec_w),
      .reload_i   (complete_w),
      .pend_o     (pend_w),
      .exp_o      (exp_w),
      .pend_nxt_o (pend_nxt_w),
      .underrun_o (underrun_w)
   );

   txb_tx_ctr #(.TW(TX_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (is_init | complete_w),
      .add_val_i (add_w),
      .sub_val_i (sub_w),
      .cnt_o     (tx_w),
      .cnt_nxt_o (tx_nxt_w),
      .fault_o   (tx_fault_w)
   );

   txb_phase_ctl #(.ERR_STICKY(ERR_STICKY)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_i     (is_init),
      .event_i    (event_w),
      .fault_i    (fault_w),
      .arr_zero_i (pend_nxt_w == '0),
      .tx_zero_i  (tx_nxt_w == '0),
      .complete_o (complete_w),
      .phase_o    (phase_o),
      .armed_o    (armed_w),
      .done_o     (done_o),
      .err_o      (err_o)
   );

   assign pending_o   = pend_w;
   assign tx_count_o  = tx_w;
   assign test_done_o = (test_parity != phase_o);
endmodule

// File: rtl/txb_checker.sv
module txb_checker #(
   parameter int AW = 16,
   parameter int TW = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic [2:0]    cmd_op,
   input logic          done_valid,
   input logic          armed,
   input logic          phase_o,
   input logic [AW-1:0] pending_o,
   input logic [AW-1:0] exp_cnt,
   input logic [TW-1:0] tx_count_o,
   input logic          done_o,
   input logic          err_o
);
   logic init_c, arrive_c;
   assign init_c   = cmd_valid && (cmd_op == 3'd1);
   assign arrive_c = cmd_valid && ((cmd_op == 3'd2) || (cmd_op == 3'd4));

   // R8
   phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_o != $past(phase_o)) && !$past(init_c)) |-> done_o);

   // R8
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((pending_o == exp_cnt) && (tx_count_o == '0)));

   // R7
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(tx_count_o) != '0) && !$past(done_valid) && !$past(init_c)) |-> !done_o);

   // R10
   underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(armed) && $past(arrive_c) && ($past(pending_o) == '0) && !$past(init_c)) |-> err_o);

   // R3
   pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pending_o <= exp_cnt);
endmodule

bind txn_phase_barrier txb_checker #(.AW(ARRIVE_W), .TW(TX_W)) u_txb_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .done_valid (done_valid),
   .armed      (armed_w),
   .phase_o    (phase_o),
   .pending_o  (pending_o),
   .exp_cnt    (exp_w),
   .tx_count_o (tx_count_o),
   .done_o     (done_o),
   .err_o      (err_o)
);

// File: tb/test_txn_phase_barrier.sv
module test_txn_phase_barrier;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 4;
   localparam int TW   = 6;
   localparam int TMAX = (1 << TW) - 1;

   logic          clk, rst_n, cmd_valid, done_valid, test_parity;
   logic [2:0]    cmd_op;
   logic [TW-1:0] cmd_arg, done_amount;
   logic          test_done_o, phase_o, done_o, err_o;
   logic [AW-1:0] pending_o;
   logic [TW-1:0] tx_count_o;

   int n_chk = 0, n_bad = 0;
   int m_phase = 0, m_pend = 0, m_exp = 0, m_tx = 0, m_err = 0, m_armed = 0;
   bit tp = 1'b0;

   txn_phase_barrier #(.ARRIVE_W(AW), .TX_W(TW), .ERR_STICKY(1'b1)) i_txn_phase_barrier (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_arg(cmd_arg), .done_valid(done_valid), .done_amount(done_amount),
      .test_parity(test_parity), .test_done_o(test_done_o), .phase_o(phase_o),
      .pending_o(pending_o), .tx_count_o(tx_count_o), .done_o(done_o), .err_o(err_o)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic check_all(input int exp_done);
      chk(done_o == exp_done[0], "R6/R7 done pulse", int'(done_o), exp_done);
      chk(int'(phase_o) == m_phase, "R8 phase", int'(phase_o), m_phase);
      chk(int'(pending_o) == m_pend, "R3 pending", int'(pending_o), m_pend);
      chk(int'(tx_count_o) == m_tx, "R4/R5 tx count", int'(tx_count_o), m_tx);
      chk(int'(err_o) == m_err, "R10 error", int'(err_o), m_err);
      chk(test_done_o == (int'(tp) != m_phase), "R9 parity test",
          int'(test_done_o), int'(int'(tp) != m_phase));
   endtask

   // One cycle: drive, advance the model per R2..R10, sample after the edge.
   task automatic step(input int op, input bit cv, input int arg, input bit dv, input int amt);
      int  e_done, np, nt, sum, add, sub;
      bit  init, act, arr, isadd, ev, fault;
      cmd_valid = cv; cmd_op = op[2:0]; cmd_arg = arg[TW-1:0];
      done_valid = dv; done_amount = amt[TW-1:0]; test_parity = tp;
      init = cv && (op == 1);
      act  = (m_armed != 0) && !init;
      arr  = cv && (op == 2 || op == 4);
      isadd = cv && (op == 3 || op == 4);
      e_done = 0;
      if (init) begin
         m_pend = arg % (1 << AW); m_exp = m_pend; m_tx = 0;
         m_phase = 0; m_err = 0; m_armed = 1;
      end else if (act) begin
         ev = arr || isadd || dv;
         fault = 1'b0;
         np = m_pend;
         if (arr) begin
            if (m_pend == 0) fault = 1'b1; else np = m_pend - 1;
         end
         add = isadd ? (arg % (TMAX + 1)) : 0;
         sub = dv ? (amt % (TMAX + 1)) : 0;
         sum = m_tx + add;
         if (sum > TMAX) begin sum = TMAX; fault = 1'b1; end
         if (sub > sum) begin nt = 0; fault = 1'b1; end else nt = sum - sub;
         if (ev && !fault && np == 0 && nt == 0) begin
            e_done = 1; m_phase ^= 1; m_pend = m_exp; m_tx = 0;
         end else begin
            m_pend = np; m_tx = nt;
         end
         if (fault) m_err = 1;
      end
      @(negedge clk);
      check_all(e_done);
      cmd_valid = 1'b0; done_valid = 1'b0;
      tp = ~tp;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_arg = '0;
      done_valid = 1'b0; done_amount = '0; test_parity = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_all(0);
      // R1 commands ignored before init
      step(2, 1, 0, 0, 0);
      step(3, 1, 9, 1, 0);
      step(4, 1, 5, 0, 0);

      for (int c = 1; c < (1 << AW); c++) begin
         for (int mode = 0; mode < 3; mode++) begin
            step(1, 1, c, 0, 0); // R2
            for (int rnd = 0; rnd < 2; rnd++) begin
               if (mode == 0) begin
                  for (int k = 0; k < c; k++) step(2, 1, 0, 0, 0); // R3 R6
                  step(0, 0, 0, 0, 0); // R6 single pulse
               end else if (mode == 1) begin
                  step(4, 1, 3 * c, 0, 0); // R4 fused
                  for (int k = 1; k < c; k++) step(2, 1, 0, 0, 0);
                  step(0, 0, 0, 0, 0); // R7 no completion while tx remains
                  step(0, 0, 0, 1, 3 * c - 1);
                  step(0, 0, 0, 1, 1); // R5 R8
               end else begin
                  step(3, 1, c + 7, 0, 0); // R4 expect
                  for (int k = 1; k < c; k++) step(2, 1, 0, 0, 0);
                  step(2, 1, 0, 1, c + 7); // R5 same-cycle arrive + completion
               end
            end
         end
      end

      // R10 arrival underrun
      step(1, 1, 0, 0, 0);
      step(2, 1, 0, 0, 0);
      step(1, 1, 2, 0, 0); // R2 clears error
      // R4 unknown op codes have no effect
      for (int op = 5; op < 8; op++) step(op, 1, 17, 0, 0);
      step(0, 1, 17, 0, 0);
      // R10 overflow saturates at the ceiling
      step(3, 1, 60, 0, 0);
      step(3, 1, 10, 0, 0);
      step(2, 1, 0, 0, 0);
      step(2, 1, 0, 1, TMAX); // completes
      // R10 underflow saturates at zero
      step(1, 1, 1, 0, 0);
      step(3, 1, 4, 0, 0);
      step(0, 0, 0, 1, 5);
      step(2, 1, 0, 0, 0); // tx is 0, pending 0: completes
      step(0, 0, 0, 0, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule